// File: doc/BRIEF.md
# PLL Power-Up Sequencer

This block steps a clock-multiplier PLL from its powered-down reset state into active multiplied-clock operation. It runs from the reference input clock and drives the three control levels the PLL needs: a power-down control, an active-low PLL reset control and an enable that selects between bypass and the multiplied clock. A start request launches the sequence. The block then releases power-down and waits for the analog regulators to settle. It holds the PLL in reset for a minimum time, then releases reset while still in bypass. Only after the lock interval does it raise the enable.

Each wait is a number of reference-clock cycles set by a parameter. The defaults suit a 27 MHz reference: 4050 cycles (150 µs) for settling, 128 cycles for reset hold and 2000 cycles for lock. The cycle counts are meant to be sized for references between 20 and 30 MHz. One down-counter is shared by all three waits. A busy flag covers the whole sequence and a done flag marks active PLL mode. A re-power request in active mode powers the PLL down for one cycle and runs the full sequence again.

Top module: `pllseq_ctrl`

## Requirements
- R1: While `rst` is sampled high, and in the cycle after, the outputs are `pll_pwrdn`=1, `pll_rst_n`=0, `pll_en`=0, `busy`=0 and `done`=0, whatever state the sequence was in.
- R2: `start` sampled high in idle clears `pll_pwrdn` and sets `busy` in the next cycle. `start` has no effect in any other state.
- R3: After `pll_pwrdn` falls, `pll_rst_n` stays 0 (PLL held in reset) for exactly SETTLE_CYC + RSTHOLD_CYC cycles, then rises to 1. With the defaults this is 4178 cycles.
- R4: `pll_en` (1 = multiplied clock, 0 = bypass) rises exactly LOCK_CYC cycles after `pll_rst_n` rises (2000 by default). It is 0 in every earlier phase.
- R5: In active mode `done`=1, `busy`=0, `pll_en`=1, `pll_rst_n`=1 and `pll_pwrdn`=0. This holds until reset or a re-power request.
- R6: `busy` is 1 in every cycle from the fall of `pll_pwrdn` until the rise of `pll_en`.
- R7: `repower` sampled high in active mode gives, in the next cycle, `pll_pwrdn`=1, `pll_en`=0, `pll_rst_n`=0, `done`=0 and `busy`=1. In the cycle after that `pll_pwrdn` is 0 again and the full R3/R4 timing repeats.
- R8: `repower` has no effect outside active mode. Neither the idle outputs nor the timing of a running sequence changes.
- R9: A reset in the middle of a sequence returns the block to idle. A later `start` runs the complete sequence with full R3/R4 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that times every wait |
| rst | input | 1 | Synchronous active-high system reset |
| start | input | 1 | Start request, honoured in idle only |
| repower | input | 1 | Re-power request, honoured in active mode only |
| pll_pwrdn | output | 1 | PLL power-down control, 1 = powered down |
| pll_rst_n | output | 1 | PLL reset control, 0 = held in reset |
| pll_en | output | 1 | PLL mode select, 1 = multiplied clock, 0 = bypass |
| busy | output | 1 | High while a sequence phase is in progress |
| done | output | 1 | High while the PLL is in active mode |

## Verification
The assertions check on every cycle the port relations that never change:
- the enable is never high while the PLL is in reset or powered down;
- done and busy are never high together;
- power-down only falls into a busy phase;
- the reset and enable rises happen only when the shared counter reaches zero;
- reset always forces the idle outputs.

Only the bench's scenarios can show that the intervals have their exact lengths in cycles. The same holds for whether start and re-power requests are ignored in the wrong states, and whether a re-power or a mid-sequence reset reruns the full timing.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_REPWR,
        PS_SETTLE,
        PS_RSTHOLD,
        PS_LOCKWAIT,
        PS_ACTIVE
    } pseq_state_e;

    typedef struct packed {
        logic pwrdn;
        logic rst_n;
        logic en;
        logic busy;
        logic done;
    } pll_ctl_t;

    // Control levels presented to the PLL in each state
    function automatic pll_ctl_t decode_ctl(pseq_state_e s);
        pll_ctl_t c;
        c = '{pwrdn: 1'b1, rst_n: 1'b0, en: 1'b0, busy: 1'b0, done: 1'b0};
        case (s)
            PS_REPWR:    c = '{pwrdn: 1'b1, rst_n: 1'b0, en: 1'b0, busy: 1'b1, done: 1'b0};
            PS_SETTLE:   c = '{pwrdn: 1'b0, rst_n: 1'b0, en: 1'b0, busy: 1'b1, done: 1'b0};
            PS_RSTHOLD:  c = '{pwrdn: 1'b0, rst_n: 1'b0, en: 1'b0, busy: 1'b1, done: 1'b0};
            PS_LOCKWAIT: c = '{pwrdn: 1'b0, rst_n: 1'b1, en: 1'b0, busy: 1'b1, done: 1'b0};
            PS_ACTIVE:   c = '{pwrdn: 1'b0, rst_n: 1'b1, en: 1'b1, busy: 1'b0, done: 1'b1};
            default:     c = '{pwrdn: 1'b1, rst_n: 1'b0, en: 1'b0, busy: 1'b0, done: 1'b0};
        endcase
        return c;
    endfunction

    // States whose length is set by the shared counter
    function automatic logic is_timed(pseq_state_e s);
        return (s == PS_SETTLE) || (s == PS_RSTHOLD) || (s == PS_LOCKWAIT);
    endfunction

endpackage

// File: rtl/pllseq_timer.sv
module pllseq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pllseq_fsm.sv
module pllseq_fsm
    import pllseq_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SETTLE_CYC  = 4050,
    parameter int RSTHOLD_CYC = 128,
    parameter int LOCK_CYC    = 2000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             repower,
    input  logic             expired,
    output pseq_state_e      state,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);

    // The counter is loaded with N-1, so each phase lasts exactly N cycles
    localparam logic [CNT_W-1:0] SETTLE_LD  = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] RSTHOLD_LD = CNT_W'(RSTHOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LOCK_LD    = CNT_W'(LOCK_CYC - 1);

    pseq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            PS_IDLE:     if (start)   state_d = PS_SETTLE;
            PS_REPWR:                 state_d = PS_SETTLE;
            PS_SETTLE:   if (expired) state_d = PS_RSTHOLD;
            PS_RSTHOLD:  if (expired) state_d = PS_LOCKWAIT;
            PS_LOCKWAIT: if (expired) state_d = PS_ACTIVE;
            PS_ACTIVE:   if (repower) state_d = PS_REPWR;
            default:                  state_d = PS_IDLE;
        endcase
    end

    always_comb begin
        case (state_d)
            PS_SETTLE:   load_val = SETTLE_LD;
            PS_RSTHOLD:  load_val = RSTHOLD_LD;
            PS_LOCKWAIT: load_val = LOCK_LD;
            default:     load_val = '0;
        endcase
        load = (state_d != state_q) && is_timed(state_d);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_IDLE;
        else     state_q <= state_d;
    end

    assign state = state_q;

    // A timed phase never ends before the counter has run out
    assert_phase_exit_on_expiry_R3: assert property (@(posedge clk) disable iff (rst)
        (is_timed(state_q) && state_d != state_q) |-> expired);

endmodule

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
    import pllseq_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SETTLE_CYC  = 4050,
    parameter int RSTHOLD_CYC = 128,
    parameter int LOCK_CYC    = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic repower,
    output logic pll_pwrdn,
    output logic pll_rst_n,
    output logic pll_en,
    output logic busy,
    output logic done
);

    localparam longint CNT_SPAN = longint'(1) << CNT_W;

    generate
        if (SETTLE_CYC < 1 || RSTHOLD_CYC < 1 || LOCK_CYC < 1) begin : g_bad_count
            $error("pllseq_ctrl: every phase count must be nonzero");
        end
        if (SETTLE_CYC > CNT_SPAN || RSTHOLD_CYC > CNT_SPAN || LOCK_CYC > CNT_SPAN) begin : g_bad_width
            $error("pllseq_ctrl: a phase count does not fit CNT_W");
        end
    endgenerate

    pseq_state_e      state;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;
    pll_ctl_t         ctl;

    pllseq_fsm #(
        .CNT_W      (CNT_W),
        .SETTLE_CYC (SETTLE_CYC),
        .RSTHOLD_CYC(RSTHOLD_CYC),
        .LOCK_CYC   (LOCK_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .repower (repower),
        .expired (expired),
        .state   (state),
        .load    (load),
        .load_val(load_val)
    );

    pllseq_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .load_val(load_val),
        .expired (expired)
    );

    assign ctl       = decode_ctl(state);
    assign pll_pwrdn = ctl.pwrdn;
    assign pll_rst_n = ctl.rst_n;
    assign pll_en    = ctl.en;
    assign busy      = ctl.busy;
    assign done      = ctl.done;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (pll_pwrdn && !pll_rst_n && !pll_en && !busy && !done));

    assert_rst_release_on_expiry_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_rst_n) |-> $past(expired));

    assert_en_on_expiry_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_en) |-> ($past(expired) && $past(pll_rst_n)));

    assert_en_needs_release_R4: assert property (@(posedge clk) disable iff (rst)
        pll_en |-> (pll_rst_n && !pll_pwrdn));

    assert_done_busy_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

    assert_pwrdn_fall_busy_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(pll_pwrdn) |-> busy);

    assert_repower_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (done && repower) |=> (pll_pwrdn && !pll_en && busy));

endmodule

// File: tb/pllseq_ctrl_bench.sv
`timescale 1ns/1ps
module pllseq_ctrl_bench;

    localparam int SETTLE  = 4050;
    localparam int RSTHOLD = 128;
    localparam int LOCK    = 2000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic repower = 1'b0;
    logic pll_pwrdn, pll_rst_n, pll_en, busy, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pllseq_ctrl u_pllseq_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .repower  (repower),
        .pll_pwrdn(pll_pwrdn),
        .pll_rst_n(pll_rst_n),
        .pll_en   (pll_en),
        .busy     (busy),
        .done     (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int outs();
        return {27'd0, pll_pwrdn, pll_rst_n, pll_en, busy, done};
    endfunction

    // Output codes {pwrdn,rst_n,en,busy,done}
    localparam int IDLE_CODE   = 5'b10000;
    localparam int ACTIVE_CODE = 5'b01101;
    localparam int REPWR_CODE  = 5'b10010;

    // Called at the negedge right after the edge that left idle/re-power.
    // inject >= 0 pulses start and repower at that lock-wait cycle.
    task automatic measure(input int inject, output int n_low, output int n_lock,
                           output int busy_bad);
        n_low = 0; n_lock = 0; busy_bad = 0;
        while (!pll_rst_n && n_low < 20000) begin
            if (!busy || pll_pwrdn || pll_en) busy_bad++;
            n_low++;
            @(negedge clk);
        end
        while (!pll_en && n_lock < 20000) begin
            if (!busy || !pll_rst_n || pll_pwrdn) busy_bad++;
            start   = (n_lock == inject);
            repower = (n_lock == inject);
            n_lock++;
            @(negedge clk);
        end
        start = 1'b0; repower = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_timing(input string tag, input int inject);
        int n_low, n_lock, bad;
        measure(inject, n_low, n_lock, bad);
        check(n_low == SETTLE + RSTHOLD, "R3", {tag, " reset-low cycles"}, n_low, SETTLE + RSTHOLD);
        check(n_lock == LOCK, "R4", {tag, " lock cycles with en=0"}, n_lock, LOCK);
        check(bad == 0, "R6", {tag, " busy/level errors during sequence"}, bad, 0);
        check(outs() == ACTIVE_CODE, "R5", {tag, " active outputs"}, outs(), ACTIVE_CODE);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(outs() == IDLE_CODE, "R1", "outputs while in reset", outs(), IDLE_CODE);
        rst = 1'b0;
        @(negedge clk);
        check(outs() == IDLE_CODE, "R1", "outputs after reset release", outs(), IDLE_CODE);
    endtask

    task automatic t_idle_ignores_repower();
        repower = 1'b1;
        @(negedge clk);
        repower = 1'b0;
        repeat (3) @(negedge clk);
        check(outs() == IDLE_CODE, "R8", "repower in idle", outs(), IDLE_CODE);
    endtask

    task automatic t_full_sequence();
        pulse_start();
        check(pll_pwrdn == 1'b0 && busy == 1'b1, "R2", "start leaves idle",
              {pll_pwrdn, busy}, 2'b01);
        check_timing("first", -1);
        repeat (50) @(negedge clk);
        check(outs() == ACTIVE_CODE, "R5", "active held", outs(), ACTIVE_CODE);
        pulse_start();
        repeat (5) @(negedge clk);
        check(outs() == ACTIVE_CODE, "R2", "start ignored in active", outs(), ACTIVE_CODE);
    endtask

    task automatic t_repower();
        repower = 1'b1;
        @(negedge clk);
        repower = 1'b0;
        check(outs() == REPWR_CODE, "R7", "re-power cycle outputs", outs(), REPWR_CODE);
        @(negedge clk);
        check(pll_pwrdn == 1'b0 && busy == 1'b1, "R7", "power-down cleared after re-power",
              {pll_pwrdn, busy}, 2'b01);
        check_timing("R7 rerun", 700);
    endtask

    task automatic t_midway_reset();
        pulse_start();
        repeat (1000) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(outs() == IDLE_CODE, "R9", "mid-sequence reset to idle", outs(), IDLE_CODE);
        repeat (10) @(negedge clk);
        check(outs() == IDLE_CODE, "R9", "stays idle without start", outs(), IDLE_CODE);
        pulse_start();
        check_timing("R9 after reset", -1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_idle_ignores_repower();
        t_full_sequence();
        t_repower();          // R8: repower and start injected during lock wait
        t_midway_reset();
        t_reset();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(2_000_000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule